// File: doc/BRIEF.md
# Configuration Bit Address Calculator

This block maps the logical position of one lookup-table bit (logic-block row and column, slice, F or G table, bit index, write or readback direction) to its physical place in a configuration bitstream. In that bitstream the device is stored column by column, and each column is split into 48 frames. The device's column count and frame length (in 32-bit words) are inputs, so one instance can serve devices of different sizes.

One start pulse captures every input. Column folding, frame selection and bit placement are computed combinationally from the captured values. The frame start word needs a product of the frame length and a frame base, and a shift-add multiplier forms it one bit per cycle. A one-cycle done pulse then presents every output together. The outputs are: the column (major) address, the frame (minor) address, the bit index inside the frame, the word where the frame starts, the word offset and bit position inside the frame, and the absolute word number. Inputs that do not describe a real location raise an error flag and force the addresses to zero.

Top module: `cfg_bitaddr_calc`

## Requirements
- R1: After reset, done_o and err_o are low and every address output is zero.
- R2: The column address folds from the device centre. When 2·col ≤ ncols it is ncols − 2·col + 2. Otherwise it is 2·col − ncols − 1.
- R3: The frame address is bit + 32 − slice·(2·bit + 17). Slice 0 gives bit + 32 and slice 1 gives 15 − bit, so the value always lies in 0..47.
- R4: The frame bit index is 3 + 18·row − G + 32·RW, where G = 1 selects the G table and RW = 1 selects readback. The word offset is floor(index / 32) and the bit position is 31 + 32·offset − index.
- R5: The start word is FL·(8 + (major − 1)·48 + minor) + RW·FL, with FL taken from flen_i.
- R6: The absolute word equals the start word plus the word offset.
- R7: done_o is high for exactly one cycle on the (FL_W+3)th rising edge, counting the edge that samples start_i. The outputs keep their values until the next done_o.
- R8: A start_i pulse that arrives while a computation is in progress is ignored. It changes neither the result nor the number of done pulses.
- R9: Each of the following sets err_o at done and forces every address output to zero: column 0, column above ncols_i, row 0, slice code above 1, or bit index above 15.
- R10: An odd column count cannot be folded evenly about the centre, so it also sets err_o with zeroed outputs.
- R11: For 30 columns, FL = 14, row 1, column 1, slice 0, F table, bit 14 and write, the outputs are major 30, minor 46, frame bit index 21, start word 20244, offset 0 and bit position 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request; captures all location inputs |
| row_i | input | ROW_W | Logic-block row, starting at 1 |
| col_i | input | COL_W | Logic-block column, starting at 1 |
| slice_i | input | 2 | Slice number; only 0 and 1 are valid |
| lut_g_i | input | 1 | 1 = G table, 0 = F table |
| bit_i | input | 5 | Bit inside the table; 0..15 valid |
| rdbk_i | input | 1 | 1 = readback position, 0 = write position |
| ncols_i | input | COL_W | Device column count |
| flen_i | input | FL_W | Frame length in 32-bit words |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Invalid location at the last completion |
| major_o | output | COL_W | Column address |
| minor_o | output | 6 | Frame address inside the column |
| fbi_o | output | FBI_W | Bit index inside the frame |
| woff_o | output | FBI_W−5 | Word offset inside the frame |
| bitpos_o | output | 5 | Bit position inside that word |
| start_word_o | output | WORD_W | Bitstream word where the frame starts |
| abs_word_o | output | WORD_W | Bitstream word holding the bit |

## Verification
The bench builds the block with ROW_W = 3, COL_W = 5, FL_W = 4 and WORD_W = 24. These widths are small enough to sweep every row from 1 to 7, every column of an 8-column device, both slices, both tables, all 16 bits and both directions. The frame length changes with the position, which exercises the multiplier across 1..15. COL_W = 5 still reaches the 30-column worked example. Each error cause and the odd column count are driven one at a time, and a second start is driven in the middle of a computation.

// File: rtl/cba_pkg.sv
package cba_pkg;
  localparam int WORD_BITS      = 32;
  localparam int CLB_FRAME_BITS = 18;
  localparam int CLOCK_COLS     = 8;
  localparam int FRAMES_PER_COL = 48;
  localparam int FBI_BASE       = 3;
  localparam int LUT_DEPTH      = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_MUL  = 2'd2,
    ST_FIN  = 2'd3
  } cba_state_e;
endpackage

// File: rtl/cba_col_map.sv
module cba_col_map #(
  parameter int COL_W = 7
) (
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] ncols_i,
  output logic [COL_W-1:0] major_o,
  output logic             col_err_o
);
  localparam int EW = COL_W + 1;

  function automatic logic [COL_W-1:0] fold_major(input logic [COL_W-1:0] col,
                                                   input logic [COL_W-1:0] ncols);
    logic [EW-1:0] twice;
    logic [EW-1:0] cnt;
    logic [EW-1:0] res;
    twice = {col, 1'b0};
    cnt   = {1'b0, ncols};
    if (twice <= cnt) res = cnt - twice + EW'(2);
    else              res = twice - cnt - EW'(1);
    return res[COL_W-1:0];
  endfunction

  assign major_o   = fold_major(col_i, ncols_i);
  assign col_err_o = (col_i == '0) || (col_i > ncols_i) || ncols_i[0];
endmodule

// File: rtl/cba_frame_pos.sv
module cba_frame_pos
  import cba_pkg::*;
#(
  parameter int ROW_W = 6,
  parameter int FBI_W = 11
) (
  input  logic [ROW_W-1:0] row_i,
  input  logic [1:0]       slice_i,
  input  logic             lut_g_i,
  input  logic [4:0]       bit_i,
  input  logic             rdbk_i,
  output logic [5:0]       minor_o,
  output logic [FBI_W-1:0] fbi_o,
  output logic [FBI_W-6:0] woff_o,
  output logic [4:0]       bpos_o,
  output logic             pos_err_o
);
  function automatic logic [5:0] minor_of(input logic [4:0] b, input logic s);
    logic [6:0] m;
    m = 7'(b) + 7'(WORD_BITS);
    if (s) m = m - (7'(b) * 7'd2 + 7'd17);
    return m[5:0];
  endfunction

  function automatic logic [FBI_W-1:0] fbi_of(input logic [ROW_W-1:0] r,
                                              input logic g, input logic rw);
    logic [FBI_W-1:0] v;
    v = FBI_W'(FBI_BASE) + FBI_W'(CLB_FRAME_BITS) * FBI_W'(r) - FBI_W'(g);
    if (rw) v = v + FBI_W'(WORD_BITS);
    return v;
  endfunction

  assign minor_o   = minor_of(bit_i, slice_i[0]);
  assign fbi_o     = fbi_of(row_i, lut_g_i, rdbk_i);
  assign woff_o    = fbi_o[FBI_W-1:5];
  assign bpos_o    = 5'd31 - fbi_o[4:0];
  assign pos_err_o = (row_i == '0) || (slice_i > 2'd1) || (bit_i > 5'(LUT_DEPTH - 1));
endmodule

// File: rtl/cba_seq_mul.sv
module cba_seq_mul #(
  parameter int A_W = 13,
  parameter int B_W = 8,
  localparam int P_W = A_W + B_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [A_W-1:0] mcand_i,
  input  logic [B_W-1:0] mplier_i,
  output logic [P_W-1:0] prod_o
);
  logic [P_W-1:0] mc_q;
  logic [B_W-1:0] mp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_o <= '0;
      mc_q   <= '0;
      mp_q   <= '0;
    end else if (load_i) begin
      prod_o <= '0;
      mc_q   <= P_W'(mcand_i);
      mp_q   <= mplier_i;
    end else if (step_i) begin
      if (mp_q[0]) prod_o <= prod_o + mc_q;
      mc_q <= mc_q << 1;
      mp_q <= mp_q >> 1;
    end
  end

  AST_MUL_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (prod_o == '0) && (mp_q == $past(mplier_i))); // R5
endmodule

// File: rtl/cfg_bitaddr_calc.sv
module cfg_bitaddr_calc
  import cba_pkg::*;
#(
  parameter int ROW_W  = 6,
  parameter int COL_W  = 7,
  parameter int FL_W   = 8,
  parameter int WORD_W = 24,
  localparam int FBI_MAX = FBI_BASE + CLB_FRAME_BITS * ((1 << ROW_W) - 1) + WORD_BITS,
  localparam int FBI_W   = $clog2(FBI_MAX + 1),
  localparam int WOFF_W  = FBI_W - 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [1:0]        slice_i,
  input  logic              lut_g_i,
  input  logic [4:0]        bit_i,
  input  logic              rdbk_i,
  input  logic [COL_W-1:0]  ncols_i,
  input  logic [FL_W-1:0]   flen_i,
  output logic              done_o,
  output logic              err_o,
  output logic [COL_W-1:0]  major_o,
  output logic [5:0]        minor_o,
  output logic [FBI_W-1:0]  fbi_o,
  output logic [WOFF_W-1:0] woff_o,
  output logic [4:0]        bitpos_o,
  output logic [WORD_W-1:0] start_word_o,
  output logic [WORD_W-1:0] abs_word_o
);
  localparam int K_W    = COL_W + 6;
  localparam int PROD_W = K_W + FL_W;
  localparam int CNT_W  = $clog2(FL_W + 1);

  cba_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [1:0]        slice_q;
  logic              lutg_q;
  logic [4:0]        bit_q;
  logic              rdbk_q;
  logic [COL_W-1:0]  ncols_q;
  logic [FL_W-1:0]   flen_q;

  logic [COL_W-1:0]  major_w;
  logic              col_err_w;
  logic [5:0]        minor_w;
  logic [FBI_W-1:0]  fbi_w;
  logic [WOFF_W-1:0] woff_w;
  logic [4:0]        bpos_w;
  logic              pos_err_w;
  logic [K_W-1:0]    base_w;
  logic [PROD_W-1:0] prod_w;

  // Named internal events
  logic busy_w, accept_w, ignored_w, last_step_w, finish_w, loc_err_w;
  assign busy_w      = (state_q != ST_IDLE);
  assign accept_w    = start_i && !busy_w;
  assign ignored_w   = start_i && busy_w;
  assign last_step_w = (state_q == ST_MUL) && (cnt_q == CNT_W'(FL_W - 1));
  assign finish_w    = (state_q == ST_FIN);
  assign loc_err_w   = col_err_w || pos_err_w;

  // Frame base; the readback shift of one frame is folded in as +RW
  function automatic logic [K_W-1:0] frame_base(input logic [COL_W-1:0] maj,
                                                input logic [5:0] mn, input logic rw);
    return K_W'(CLOCK_COLS) + (K_W'(maj) - K_W'(1)) * K_W'(FRAMES_PER_COL)
           + K_W'(mn) + K_W'(rw);
  endfunction

  cba_col_map #(.COL_W(COL_W)) u_col (
    .col_i(col_q), .ncols_i(ncols_q), .major_o(major_w), .col_err_o(col_err_w)
  );

  cba_frame_pos #(.ROW_W(ROW_W), .FBI_W(FBI_W)) u_pos (
    .row_i(row_q), .slice_i(slice_q), .lut_g_i(lutg_q), .bit_i(bit_q),
    .rdbk_i(rdbk_q), .minor_o(minor_w), .fbi_o(fbi_w), .woff_o(woff_w),
    .bpos_o(bpos_w), .pos_err_o(pos_err_w)
  );

  assign base_w = frame_base(major_w, minor_w, rdbk_q);

  cba_seq_mul #(.A_W(K_W), .B_W(FL_W)) u_mul (
    .clk(clk), .rst_n(rst_n),
    .load_i(state_q == ST_LOAD), .step_i(state_q == ST_MUL),
    .mcand_i(base_w), .mplier_i(flen_q), .prod_o(prod_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      row_q   <= '0;
      col_q   <= '0;
      slice_q <= '0;
      lutg_q  <= 1'b0;
      bit_q   <= '0;
      rdbk_q  <= 1'b0;
      ncols_q <= '0;
      flen_q  <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      major_o <= '0;
      minor_o <= '0;
      fbi_o   <= '0;
      woff_o  <= '0;
      bitpos_o     <= '0;
      start_word_o <= '0;
      abs_word_o   <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept_w) begin
          row_q   <= row_i;
          col_q   <= col_i;
          slice_q <= slice_i;
          lutg_q  <= lut_g_i;
          bit_q   <= bit_i;
          rdbk_q  <= rdbk_i;
          ncols_q <= ncols_i;
          flen_q  <= flen_i;
          state_q <= ST_LOAD;
        end
        ST_LOAD: begin
          cnt_q   <= '0;
          state_q <= ST_MUL;
        end
        ST_MUL: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (last_step_w) state_q <= ST_FIN;
        end
        ST_FIN: begin
          done_o  <= 1'b1;
          err_o   <= loc_err_w;
          state_q <= ST_IDLE;
          if (loc_err_w) begin
            major_o <= '0;
            minor_o <= '0;
            fbi_o   <= '0;
            woff_o  <= '0;
            bitpos_o     <= '0;
            start_word_o <= '0;
            abs_word_o   <= '0;
          end else begin
            major_o <= major_w;
            minor_o <= minor_w;
            fbi_o   <= fbi_w;
            woff_o  <= woff_w;
            bitpos_o     <= bpos_w;
            start_word_o <= WORD_W'(prod_w);
            abs_word_o   <= WORD_W'(prod_w + PROD_W'(woff_w));
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_DONE_AFTER_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(finish_w)); // R7
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ignored_w |=> $stable(row_q) && $stable(col_q) && $stable(slice_q) && $stable(bit_q)
                  && $stable(ncols_q) && $stable(flen_q) && $stable(rdbk_q)); // R8
  AST_ERR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> (major_o == '0) && (minor_o == '0) && (fbi_o == '0)
                          && (start_word_o == '0) && (abs_word_o == '0)); // R9
  AST_MINOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (minor_o <= 6'd47)); // R3
  AST_MAJOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (major_o != '0) && (major_o <= ncols_q)); // R2
  AST_ABS_NOT_BELOW_START: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (abs_word_o >= start_word_o)); // R6
endmodule

// File: tb/cfg_bitaddr_calc_tb.sv
module cfg_bitaddr_calc_tb;
  localparam int ROW_W  = 3;
  localparam int COL_W  = 5;
  localparam int FL_W   = 4;
  localparam int WORD_W = 24;
  localparam int FBI_W  = $clog2(3 + 18 * ((1 << ROW_W) - 1) + 32 + 1);
  localparam int LAT    = FL_W + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [ROW_W-1:0] row_i = '0;
  logic [COL_W-1:0] col_i = '0;
  logic [1:0] slice_i = '0;
  logic lut_g_i = 1'b0;
  logic [4:0] bit_i = '0;
  logic rdbk_i = 1'b0;
  logic [COL_W-1:0] ncols_i = '0;
  logic [FL_W-1:0] flen_i = '0;
  logic done_o, err_o;
  logic [COL_W-1:0] major_o;
  logic [5:0] minor_o;
  logic [FBI_W-1:0] fbi_o;
  logic [FBI_W-6:0] woff_o;
  logic [4:0] bitpos_o;
  logic [WORD_W-1:0] start_word_o, abs_word_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cfg_bitaddr_calc #(.ROW_W(ROW_W), .COL_W(COL_W), .FL_W(FL_W), .WORD_W(WORD_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .row_i(row_i), .col_i(col_i),
    .slice_i(slice_i), .lut_g_i(lut_g_i), .bit_i(bit_i), .rdbk_i(rdbk_i),
    .ncols_i(ncols_i), .flen_i(flen_i), .done_o(done_o), .err_o(err_o),
    .major_o(major_o), .minor_o(minor_o), .fbi_o(fbi_o), .woff_o(woff_o),
    .bitpos_o(bitpos_o), .start_word_o(start_word_o), .abs_word_o(abs_word_o)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_400_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // Starts one request and waits for done; returns cycles seen
  task automatic launch(input int r, input int c, input int s, input int g, input int b,
                        input int rw, input int n, input int fl, output int cyc);
    @(negedge clk);
    row_i = ROW_W'(r); col_i = COL_W'(c); slice_i = 2'(s); lut_g_i = g[0];
    bit_i = 5'(b); rdbk_i = rw[0]; ncols_i = COL_W'(n); flen_i = FL_W'(fl);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic expect_all(input string tag, input int r, input int c, input int s,
                            input int g, input int b, input int rw, input int n, input int fl);
    longint maj, mn, fbi, sw, wo, bp;
    bit bad;
    bad = (c == 0) || (c > n) || (n % 2 != 0) || (r == 0) || (s > 1) || (b > 15);
    maj = (2 * c <= n) ? (n - 2 * c + 2) : (2 * c - n - 1);
    mn  = b + 32 - s * (2 * b + 17);
    fbi = 3 + 18 * r - g + 32 * rw;
    sw  = fl * (8 + (maj - 1) * 48 + mn) + rw * fl;
    wo  = fbi / 32;
    bp  = 31 + 32 * wo - fbi;
    if (bad) begin maj = 0; mn = 0; fbi = 0; sw = 0; wo = 0; bp = 0; end
    chk(bad ? "R9" : tag, "err", err_o, bad);
    chk("R2", "major", major_o, maj);
    chk("R3", "minor", minor_o, mn);
    chk("R4", "fbi", fbi_o, fbi);
    chk("R4", "woff", woff_o, wo);
    chk("R4", "bitpos", bitpos_o, bp);
    chk("R5", "start_word", start_word_o, sw);
    chk("R6", "abs_word", abs_word_o, sw + wo);
  endtask

  initial begin
    int cyc;
    // R1: reset state
    #20;
    @(negedge clk);
    chk("R1", "done", done_o, 0);
    chk("R1", "err", err_o, 0);
    chk("R1", "major", major_o, 0);
    chk("R1", "start_word", start_word_o, 0);
    chk("R1", "abs_word", abs_word_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11: worked example
    launch(1, 1, 0, 0, 14, 0, 30, 14, cyc);
    chk("R11", "major", major_o, 30);
    chk("R11", "minor", minor_o, 46);
    chk("R11", "fbi", fbi_o, 21);
    chk("R11", "start_word", start_word_o, 20244);
    chk("R11", "woff", woff_o, 0);
    chk("R11", "bitpos", bitpos_o, 10);
    chk("R11", "abs_word", abs_word_o, 20244);

    // R7: latency, single-cycle pulse, held outputs
    launch(3, 6, 1, 1, 5, 1, 8, 9, cyc);
    chk("R7", "latency", cyc, LAT);
    @(negedge clk);
    chk("R7", "done_low_after_pulse", done_o, 0);
    repeat (3) @(negedge clk);
    expect_all("R7", 3, 6, 1, 1, 5, 1, 8, 9);

    // R9, R10: each error cause alone
    launch(2, 0, 0, 0, 3, 0, 8, 5, cyc);  expect_all("R9", 2, 0, 0, 0, 3, 0, 8, 5);
    launch(2, 9, 0, 0, 3, 0, 8, 5, cyc);  expect_all("R9", 2, 9, 0, 0, 3, 0, 8, 5);
    launch(0, 2, 0, 0, 3, 0, 8, 5, cyc);  expect_all("R9", 0, 2, 0, 0, 3, 0, 8, 5);
    launch(2, 2, 2, 0, 3, 0, 8, 5, cyc);  expect_all("R9", 2, 2, 2, 0, 3, 0, 8, 5);
    launch(2, 2, 0, 0, 16, 0, 8, 5, cyc); expect_all("R9", 2, 2, 0, 0, 16, 0, 8, 5);
    launch(2, 2, 0, 0, 3, 0, 7, 5, cyc);
    chk("R10", "err_odd_count", err_o, 1);
    chk("R10", "major_odd_count", major_o, 0);
    launch(2, 2, 0, 0, 3, 0, 8, 5, cyc);
    chk("R9", "err_cleared", err_o, 0);

    // R8: second start while busy is ignored
    @(negedge clk);
    row_i = 3'd4; col_i = 5'd3; slice_i = 2'd0; lut_g_i = 1'b1; bit_i = 5'd7;
    rdbk_i = 1'b0; ncols_i = 5'd8; flen_i = 4'd6;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    row_i = 3'd6; col_i = 5'd8; bit_i = 5'd1; flen_i = 4'd11;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 3;
    while (!done_o && cyc < 40) begin @(negedge clk); cyc++; end
    chk("R8", "latency_first_request", cyc, LAT);
    expect_all("R8", 4, 3, 0, 1, 7, 0, 8, 6);
    for (int k = 0; k < LAT + 2; k++) begin
      @(negedge clk);
      if (done_o) chk("R8", "extra_done", 1, 0);
    end
    expect_all("R8", 4, 3, 0, 1, 7, 0, 8, 6);

    // R2..R6: sweep a small 8-column device
    for (int r = 1; r < 8; r++)
      for (int c = 1; c <= 8; c++)
        for (int s = 0; s < 2; s++)
          for (int g = 0; g < 2; g++)
            for (int b = 0; b < 16; b++)
              for (int rw = 0; rw < 2; rw++) begin
                int fl;
                fl = 1 + ((r + c + b) % 15);
                launch(r, c, s, g, b, rw, 8, fl, cyc);
                if (cyc != LAT) chk("R7", "sweep_latency", cyc, LAT);
                expect_all("R5", r, c, s, g, b, rw, 8, fl);
              end

    finish_run();
  end
endmodule